// File: doc/BRIEF.md
# Keyed 32-bit SPN Round Function

This block is the keyed nonlinear function used inside each round of a 64-bit block cipher built on a Lai-Massey top level. It takes a 32-bit data word, split into four bytes, and a 64-bit round key. It returns a 32-bit word.

The datapath has five stages:

1. The word is mixed with the upper key half.
2. Every byte passes through a bijective 8-bit substitution.
3. The four bytes are diffused by a 4x4 matrix product over GF(2^8).
4. The lower key half is added.
5. The bytes are substituted again, and the upper key half is added once more.

Each 8-bit substitution is a three-round Lai-Massey network of three 4-bit tables. A nibble orthomorphism is applied between the rounds, so the result is a permutation whatever the table contents are. The field multiplier is a pure AND/XOR network that reduces modulo x^8+x^7+x^6+x^5+x^4+x^3+1.

The datapath is combinational. The parameter `OUT_REG` chooses whether the result drives `dout` directly or through one register stage with asynchronous active-low reset. The block has no control states: data flows straight through the chain of stages, and the only sequential element is the optional output register. The three 4-bit tables (`SB_R0`, `SB_R1`, `SB_R2`) and the sixteen matrix coefficients (`MIX_M`) are parameters. Table entry n sits at bits [4n+3:4n]. Coefficient M[i][j] sits at bits [8(4i+j)+7 : 8(4i+j)].

Top module: `spn_round`

## Requirements
- R1: Key use follows this order: `rkey[63:32]` is XORed into the data before the first substitution and again after the second substitution; `rkey[31:0]` is XORed in after diffusion. So `dout = S(D(S(din ^ Ku)) ^ Kl) ^ Ku`, where S and D act bytewise on byte j = bits [8j+7:8j].
- R2: The 8-bit substitution is a permutation: its 256 outputs are all distinct.
- R3: The substitution splits x into left nibble L = x[7:4] and right nibble R = x[3:0]. Round k (k = 0, 1, 2) computes t = T_k[L^R], then sets L ^= t and R ^= t. After rounds 0 and 1 only, L = {a1, a1^a0}, where a1 = L[1:0] and a0 = L[3:2]. The output is {L, R}.
- R4: Field multiplication is polynomial product modulo 0x1F9. Multiplying by 0 gives 0, and multiplying by 1 returns the other operand.
- R5: Diffusion output byte i = XOR over j of M[i][j]·(input byte j). A zero word maps to zero, and a word holding 0x01 in byte j alone maps to column j of M.
- R6: With `OUT_REG`=0, `dout` follows the inputs in the same cycle and is stable whenever `din` and `rkey` are stable.
- R7: With `OUT_REG`=1, `dout` equals the combinational result captured at the previous rising edge of `clk`.
- R8: With `OUT_REG`=1, `dout` is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| din | input | 32 | Data word, byte j at bits [8j+7:8j] |
| rkey | input | 64 | Round key; upper half first and final addition, lower half after diffusion |
| dout | output | 32 | Round function result |

## Verification
The bench aims at the following corner cases, each paired with the failure it would expose:

- **Field multiplier.** It is swept over all 65536 operand pairs, including the zero and unit rows, against a shift-and-reduce model. A wrong reduction constant or a dropped partial product shows up as mismatches above 0x7F.
- **Substitution.** It is compared with an independent model of the nibble network and checked for duplicate outputs. A misplaced orthomorphism, or one applied after the last round, changes the mapping.
- **Key halves.** Words that carry only the upper half or only the lower half expose a swapped or missing key addition.
- **Diffusion.** Unit vectors in each byte lane expose a transposed matrix.
- **Output register.** A result that appears a cycle early or late, or that is not cleared during reset, fails the latency check.

// File: rtl/spn_pkg.sv
package spn_pkg;

    typedef logic [7:0] gfe_t;
    typedef logic [3:0] nib_t;

    // Reduction polynomial x^8+x^7+x^6+x^5+x^4+x^3+1
    localparam logic [8:0] GF_POLY = 9'h1F9;

    // Default 4-bit tables, entry n at bits [4n+3:4n]
    localparam logic [63:0] SB_R0_DEF = 64'h2519_EAC8_647F_DB03;
    localparam logic [63:0] SB_R1_DEF = 64'hB41F_03ED_A875_C296;
    localparam logic [63:0] SB_R2_DEF = 64'hD2B0_4E38_1CAF_6957;

    // Default mixing matrix, M[i][j] at byte 4i+j
    localparam logic [127:0] MIX_M_DEF = 128'h01FD0102_010102FD_0102FD01_02010101;

    function automatic nib_t nib_lookup(input logic [63:0] tbl, input nib_t idx);
        return tbl[{idx, 2'b00} +: 4];
    endfunction

    // One-round Feistel on 2-bit halves with identity round function
    function automatic nib_t nib_ortho(input nib_t a);
        return {a[1:0], a[3:2] ^ a[1:0]};
    endfunction

endpackage

// File: rtl/spn_gf_mul.sv
module spn_gf_mul
    import spn_pkg::*;
#(
    parameter logic [8:0] POLY = GF_POLY
) (
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] p
);
    localparam int W  = 8;
    localparam int PW = 2 * W - 1;

    logic [PW-1:0] part [0:W];
    logic [PW-1:0] red  [0:W-1];

    assign part[0] = '0;

    // AND/XOR partial-product array
    for (genvar k = 0; k < W; k++) begin : g_pp
        assign part[k+1] = part[k] ^ (({{(W-1){1'b0}}, a} << k) & {PW{b[k]}});
    end

    assign red[0] = part[W];

    // Fold high bits down, most significant first
    for (genvar m = 0; m < W - 1; m++) begin : g_red
        localparam int POS = PW - 1 - m;
        assign red[m+1] = red[m] ^ (({{(W-2){1'b0}}, POLY} << (POS - W)) & {PW{red[m][POS]}});
    end

    assign p = red[W-1][W-1:0];

    always_comb begin
        // R4
        gf_zero_chk: assert (!(a == 8'h00 || b == 8'h00) || p == 8'h00);
        // R4
        gf_one_chk: assert (b != 8'h01 || p == a);
    end

endmodule

// File: rtl/spn_sbox8.sv
module spn_sbox8
    import spn_pkg::*;
#(
    parameter logic [63:0] SB_R0 = SB_R0_DEF,
    parameter logic [63:0] SB_R1 = SB_R1_DEF,
    parameter logic [63:0] SB_R2 = SB_R2_DEF
) (
    input  logic [7:0] x,
    output logic [7:0] y
);
    localparam int ROUNDS = 3;
    localparam logic [ROUNDS-1:0][63:0] TBL = {SB_R2, SB_R1, SB_R0};

    nib_t lft [0:ROUNDS];
    nib_t rgt [0:ROUNDS];

    assign lft[0] = x[7:4];
    assign rgt[0] = x[3:0];

    for (genvar g = 0; g < ROUNDS; g++) begin : g_rnd
        nib_t t, nl;
        assign t  = nib_lookup(TBL[g], lft[g] ^ rgt[g]);
        assign nl = lft[g] ^ t;
        assign rgt[g+1] = rgt[g] ^ t;
        if (g < ROUNDS - 1) begin : g_orth
            assign lft[g+1] = nib_ortho(nl);
        end else begin : g_last
            assign lft[g+1] = nl;
        end
    end

    assign y = {lft[ROUNDS], rgt[ROUNDS]};

endmodule

// File: rtl/spn_diffuse.sv
module spn_diffuse
    import spn_pkg::*;
#(
    parameter int           LANES = 4,
    parameter logic [127:0] MIX_M = MIX_M_DEF
) (
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] dout
);
    gfe_t prod [0:LANES-1][0:LANES-1];

    for (genvar i = 0; i < LANES; i++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            spn_gf_mul #(.POLY(GF_POLY)) i_mul (
                .a (din[8*j +: 8]),
                .b (MIX_M[8*(LANES*i+j) +: 8]),
                .p (prod[i][j])
            );
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            gfe_t acc;
            acc = '0;
            for (int j = 0; j < LANES; j++) begin
                acc = acc ^ prod[i][j];
            end
            dout[8*i +: 8] = acc;
        end
    end

    always_comb begin
        // R5
        mix_zero_chk: assert (din != '0 || dout == '0);
        for (int j = 0; j < LANES; j++) begin
            if (din == ({{(8*LANES-1){1'b0}}, 1'b1} << (8*j))) begin
                for (int i = 0; i < LANES; i++) begin
                    // R5
                    mix_column_chk: assert (dout[8*i +: 8] == MIX_M[8*(LANES*i+j) +: 8]);
                end
            end
        end
    end

endmodule

// File: rtl/spn_round.sv
module spn_round
    import spn_pkg::*;
#(
    parameter bit           OUT_REG = 1'b1,
    parameter logic [63:0]  SB_R0   = SB_R0_DEF,
    parameter logic [63:0]  SB_R1   = SB_R1_DEF,
    parameter logic [63:0]  SB_R2   = SB_R2_DEF,
    parameter logic [127:0] MIX_M   = MIX_M_DEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] din,
    input  logic [63:0] rkey,
    output logic [31:0] dout
);
    localparam int LANES = 4;
    localparam int DW    = 8 * LANES;

    logic [DW-1:0] k_up, k_lo;
    logic [DW-1:0] pre_sub, sub_a, mixed, mid, sub_b, result;

    assign k_up    = rkey[2*DW-1:DW];
    assign k_lo    = rkey[DW-1:0];
    assign pre_sub = din ^ k_up;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        spn_sbox8 #(.SB_R0(SB_R0), .SB_R1(SB_R1), .SB_R2(SB_R2)) i_sub_a (
            .x (pre_sub[8*j +: 8]),
            .y (sub_a[8*j +: 8])
        );
        spn_sbox8 #(.SB_R0(SB_R0), .SB_R1(SB_R1), .SB_R2(SB_R2)) i_sub_b (
            .x (mid[8*j +: 8]),
            .y (sub_b[8*j +: 8])
        );
    end

    spn_diffuse #(.LANES(LANES), .MIX_M(MIX_M)) i_mix (
        .din  (sub_a),
        .dout (mixed)
    );

    assign mid    = mixed ^ k_lo;
    assign result = sub_b ^ k_up;

    if (OUT_REG) begin : g_reg
        logic [DW-1:0] out_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= result;
        end

        assign dout = out_q;

        // R7
        out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> dout == $past(result));
        // R8
        reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> dout == '0);
    end else begin : g_comb
        assign dout = result;

        // R6
        comb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(din) && $stable(rkey)) |-> $stable(dout));
    end

endmodule

// File: tb/test_spn_round.sv
module test_spn_round;

    localparam logic [63:0]  T0 = 64'h2519_EAC8_647F_DB03;
    localparam logic [63:0]  T1 = 64'hB41F_03ED_A875_C296;
    localparam logic [63:0]  T2 = 64'hD2B0_4E38_1CAF_6957;
    localparam logic [127:0] MM = 128'h01FD0102_010102FD_0102FD01_02010101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din = '0;
    logic [63:0] rkey = '0;
    logic [31:0] dout_r, dout_c;
    logic [7:0]  ga = '0, gb = '0, gp;
    logic [7:0]  sx = '0, sy;
    logic [31:0] mx_in = '0, mx_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spn_round #(.OUT_REG(1'b1), .SB_R0(T0), .SB_R1(T1), .SB_R2(T2), .MIX_M(MM)) i_spn_round (
        .clk(clk), .rst_n(rst_n), .din(din), .rkey(rkey), .dout(dout_r));

    spn_round #(.OUT_REG(1'b0), .SB_R0(T0), .SB_R1(T1), .SB_R2(T2), .MIX_M(MM)) i_spn_round_comb (
        .clk(clk), .rst_n(rst_n), .din(din), .rkey(rkey), .dout(dout_c));

    spn_gf_mul i_gf (.a(ga), .b(gb), .p(gp));

    spn_sbox8 #(.SB_R0(T0), .SB_R1(T1), .SB_R2(T2)) i_sbox (.x(sx), .y(sy));

    spn_diffuse #(.LANES(4), .MIX_M(MM)) i_mix (.din(mx_in), .dout(mx_out));

    // ---------------- reference models ----------------
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[7] ? ((x << 1) ^ 8'hF9) : (x << 1);
        end
        return acc;
    endfunction

    function automatic logic [7:0] ref_sbox(input logic [7:0] v);
        logic [3:0] l = v[7:4];
        logic [3:0] r = v[3:0];
        logic [63:0] tb;
        logic [3:0] t;
        for (int rd = 0; rd < 3; rd++) begin
            tb = (rd == 0) ? T0 : (rd == 1) ? T1 : T2;
            t = tb[{l ^ r, 2'b00} +: 4];
            l = l ^ t;
            r = r ^ t;
            if (rd < 2) l = {l[1:0], l[3:2] ^ l[1:0]};
        end
        return {l, r};
    endfunction

    function automatic logic [31:0] ref_mix(input logic [31:0] v);
        logic [31:0] o;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] acc = 8'h00;
            for (int j = 0; j < 4; j++) acc = acc ^ ref_mul(v[8*j +: 8], MM[8*(4*i+j) +: 8]);
            o[8*i +: 8] = acc;
        end
        return o;
    endfunction

    function automatic logic [31:0] ref_sub32(input logic [31:0] v);
        logic [31:0] o;
        for (int j = 0; j < 4; j++) o[8*j +: 8] = ref_sbox(v[8*j +: 8]);
        return o;
    endfunction

    function automatic logic [31:0] ref_round(input logic [31:0] d, input logic [63:0] k);
        return ref_sub32(ref_mix(ref_sub32(d ^ k[63:32])) ^ k[31:0]) ^ k[63:32];
    endfunction

    // ---------------- checking ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Apply one vector: check comb instance now, registered one after the edge
    task automatic apply_round(input string req, input logic [31:0] d, input logic [63:0] k);
        @(negedge clk);
        din  = d;
        rkey = k;
        #1;
        check({req, " comb"}, dout_c, ref_round(d, k));
        @(posedge clk);
        #1;
        check({req, " reg R7"}, dout_r, ref_round(d, k));
    endtask

    task automatic test_reset();
        din  = 32'hDEAD_BEEF;
        rkey = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset clear", dout_r, 32'h0);
        check("R6 comb during reset", dout_c, ref_round(din, rkey));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 after release before edge", dout_r, 32'h0);
        @(posedge clk);
        #1;
        check("R7 first capture", dout_r, ref_round(din, rkey));
    endtask

    task automatic test_gf();
        int bad = 0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                ga = a[7:0];
                gb = b[7:0];
                #1;
                if (gp !== ref_mul(a[7:0], b[7:0])) begin
                    bad++;
                    if (bad <= 4) $display("FAIL R4 gf %02h*%02h: actual %02h expected %02h",
                                           a[7:0], b[7:0], gp, ref_mul(a[7:0], b[7:0]));
                end
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_errors++;
            $display("FAIL R4 exhaustive: actual %0d mismatches expected 0", bad);
        end
        ga = 8'h80; gb = 8'h02; #1;
        check("R4 reduction 80*02", {24'h0, gp}, 32'h0000_00F9);
        ga = 8'hA7; gb = 8'h01; #1;
        check("R4 times one", {24'h0, gp}, 32'h0000_00A7);
        ga = 8'h00; gb = 8'h5C; #1;
        check("R4 times zero", {24'h0, gp}, 32'h0);
    endtask

    task automatic test_sbox();
        logic [255:0] seen = '0;
        int dup = 0;
        int bad = 0;
        for (int v = 0; v < 256; v++) begin
            sx = v[7:0];
            #1;
            if (sy !== ref_sbox(v[7:0])) begin
                bad++;
                if (bad <= 4) $display("FAIL R3 sbox %02h: actual %02h expected %02h",
                                       v[7:0], sy, ref_sbox(v[7:0]));
            end
            if (seen[sy]) dup++;
            seen[sy] = 1'b1;
        end
        check("R3 sbox model mismatches", bad, 0);
        check("R2 sbox duplicate outputs", dup, 0);
    endtask

    task automatic test_mix();
        mx_in = 32'h0; #1;
        check("R5 zero word", mx_out, 32'h0);
        for (int j = 0; j < 4; j++) begin
            logic [31:0] col;
            for (int i = 0; i < 4; i++) col[8*i +: 8] = MM[8*(4*i+j) +: 8];
            mx_in = 32'h1 << (8*j);
            #1;
            check("R5 unit column", mx_out, col);
        end
        mx_in = 32'h9A3C_71E5; #1;
        check("R5 mixed word", mx_out, ref_mix(32'h9A3C_71E5));
    endtask

    task automatic test_round();
        logic [31:0] lf = 32'hACE1_2468;
        apply_round("R1 all zero", 32'h0, 64'h0);
        apply_round("R1 upper key only", 32'h0, 64'h5A5A_F00F_0000_0000);
        apply_round("R1 lower key only", 32'h0, 64'h0000_0000_C3C3_1234);
        apply_round("R1 data only", 32'h1122_3344, 64'h0);
        for (int n = 0; n < 6; n++) begin
            logic [63:0] k;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            k[63:32] = lf ^ 32'h3C96_A55A;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            k[31:0] = lf;
            apply_round("R1 pattern", lf ^ 32'hF0F0_0F0F, k);
        end
        // hold inputs: comb output must not move
        @(negedge clk);
        #1;
        check("R6 held inputs", dout_c, ref_round(din, rkey));
    endtask

    initial begin
        #(2_000_000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        test_reset();
        test_gf();
        test_sbox();
        test_mix();
        test_round();
        finish_up();
    end

endmodule